// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block watches the minute, hour and day values of a running calendar and raises an alarm when they agree with a programmed alarm setting. The calendar counters sit outside the block. They present a BCD minute, a BCD hour, a one-hot weekday and a BCD day of the month, together with a one-cycle pulse on every minute carry. The comparison is made only on that pulse, so a matching time produces a single event per minute and never fires continuously.

The alarm setting has three fields: minute, hour, and a shared day field. A mode bit decides how the shared field is read. In weekday mode it is a mask, and any enabled weekday matches. In day mode it is a BCD day-of-month number. Bit 7 of every field tells the block to ignore that field. A hit sets a sticky flag, which only a written zero clears. The interrupt enable decides only whether the request pin is pulled low. The pin output works like an open-drain driver: when it is 1 the pin is driven low, and when it is 0 the pin is released.

The flag lives in a three-state machine:
- `ST_IDLE`: no flag.
- `ST_QUIET`: flag set, request released.
- `ST_ALERT`: flag set, request driven low.

Its transitions are:
- IDLE→QUIET on a hit while the enable is off.
- IDLE→ALERT on a hit while the enable is on.
- QUIET→ALERT when the enable is turned on.
- ALERT→QUIET when the enable is turned off.
- QUIET→IDLE and ALERT→IDLE when the flag is cleared with no hit in the same cycle.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset, `alarm_flag` and `irq_pull_low` are 0. All alarm fields are 00h and the control bits are 0, which selects weekday mode with the interrupt disabled.
- R2: The write port decodes `wr_addr` as follows:
  - 0 is the minute field: bit 7 is ignore, bits 6:0 hold the BCD minute.
  - 1 is the hour field: bit 7 is ignore, bits 6:0 hold the BCD hour, and bit 6 must be 0 to match.
  - 2 is the shared day field: bit 7 is ignore, bits 6:0 hold either a weekday mask or a BCD day, and bit 6 must be 0 to match in day mode.
  - 3 is control: bit 0 is the mode (0 = weekday mask, 1 = day of month), bit 1 is the interrupt enable, and bit 2 is the flag write.
- R3: When `min_tick` is 1 at a rising clock edge and every participating field equals the current time, `alarm_flag` reads 1 after that edge.
- R4: In weekday mode the day field matches when `cur_wday` (one-hot, 01h for the first day up to 40h for the seventh) shares any set bit with the mask. A mask can therefore enable several days at once.
- R5: In day mode the day field matches only when its value equals the BCD `cur_mday`.
- R6: A field with bit 7 set counts as matching whatever the current value is.
- R7: Without `min_tick` the flag is never set, even when every field matches.
- R8: The flag stays at 1 until a control write with bit 2 = 0. A control write with bit 2 = 1 leaves the flag unchanged.
- R9: When a hit and a flag-clearing write fall in the same cycle, the flag is 1 afterwards.
- R10: `irq_pull_low` equals the flag ANDed with the enable after every edge. The flag is set whatever the enable is. Turning the enable on while the flag is set drives the pin low, and turning it off releases the pin without clearing the flag.
- R11: A field write in the same cycle as `min_tick` takes effect after that cycle. The comparison in that cycle uses the field values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| cur_mday | input | 6 | Current day of month, BCD |
| min_tick | input | 1 | One-cycle pulse on each minute carry |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pull_low | output | 1 | 1 = drive the request pin low, 0 = release it |

## Verification
The assertions assume that `min_tick` is a single-cycle pulse and that the time inputs are held steady around it. They also assume that the only way to clear the flag is a write to address 3 with bit 2 at 0. The bench drives valid BCD times and one-hot weekdays, and it raises `min_tick` for one cycle only. In roughly half of the iterations it copies the current time into the alarm fields so that hits really occur. It also randomizes the ignore bits, the mode, the enable and the flag-write bit, and it places writes and ticks in the same cycle on purpose.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int REG_DW    = 8;
    localparam int ADDR_W    = 2;
    localparam int FIELD_N   = 3;
    localparam int IGN_BIT   = 7;

    localparam logic [ADDR_W-1:0] ADDR_MIN  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HOUR = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DAY  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_EN_BIT   = 1;
    localparam int CTRL_FLAG_BIT = 2;

    typedef struct packed {
        logic       ign;
        logic [6:0] val;
    } alarm_field_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUIET = 2'd1,
        ST_ALERT = 2'd2
    } flag_state_t;

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_DW-1:0]   wr_data,
    output alarm_field_t        fld_min,
    output alarm_field_t        fld_hour,
    output alarm_field_t        fld_day,
    output logic                mode_day,
    output logic                irq_en_q,
    output logic                irq_en_nxt,
    output logic                flag_clr
);

    alarm_field_t fields [FIELD_N];
    logic         ctrl_wr;

    // Field registers, one per alarm field, selected by address index.
    for (genvar g = 0; g < FIELD_N; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fields[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                fields[g] <= alarm_field_t'(wr_data);
            end
        end
    end

    assign fld_min  = fields[0];
    assign fld_hour = fields[1];
    assign fld_day  = fields[2];

    assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
    assign irq_en_nxt = ctrl_wr ? wr_data[CTRL_EN_BIT] : irq_en_q;
    assign flag_clr   = ctrl_wr && !wr_data[CTRL_FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_day <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_day <= wr_data[CTRL_MODE_BIT];
            irq_en_q <= wr_data[CTRL_EN_BIT];
        end
    end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_irq_pkg::*;
#(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int MDAY_W = 6,
    parameter int WDAY_N = 7
) (
    input  alarm_field_t      fld_min,
    input  alarm_field_t      fld_hour,
    input  alarm_field_t      fld_day,
    input  logic              mode_day,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_N-1:0] cur_wday,
    input  logic [MDAY_W-1:0] cur_mday,
    output logic              all_hit
);

    localparam int FV_W = 7;

    logic [FV_W-1:0] min_ext, hour_ext, mday_ext, wday_ext;
    logic            min_ok, hour_ok, day_ok, wday_ok, mday_ok;

    // Zero-extend so that unused high alarm bits must be 0 to match.
    assign min_ext  = FV_W'(cur_min);
    assign hour_ext = FV_W'(cur_hour);
    assign mday_ext = FV_W'(cur_mday);
    assign wday_ext = FV_W'(cur_wday);

    assign min_ok  = fld_min.ign  || (fld_min.val  == min_ext);
    assign hour_ok = fld_hour.ign || (fld_hour.val == hour_ext);
    assign wday_ok = |(fld_day.val & wday_ext);
    assign mday_ok = (fld_day.val == mday_ext);
    assign day_ok  = fld_day.ign || (mode_day ? mday_ok : wday_ok);

    assign all_hit = min_ok && hour_ok && day_ok;

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic flag_clr,
    input  logic irq_en_nxt,
    output logic alarm_flag,
    output logic irq_pull_low
);

    flag_state_t state_q, state_d;
    logic        drop;

    assign drop = flag_clr && !evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) state_d = irq_en_nxt ? ST_ALERT : ST_QUIET;
            end
            ST_QUIET: begin
                if (drop)            state_d = ST_IDLE;
                else if (irq_en_nxt) state_d = ST_ALERT;
            end
            ST_ALERT: begin
                if (drop)             state_d = ST_IDLE;
                else if (!irq_en_nxt) state_d = ST_QUIET;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        alarm_flag   = 1'b0;
        irq_pull_low = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_QUIET: alarm_flag = 1'b1;
            ST_ALERT: begin
                alarm_flag   = 1'b1;
                irq_pull_low = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
    import alarm_irq_pkg::*;
#(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int MDAY_W = 6,
    parameter int WDAY_N = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_N-1:0] cur_wday,
    input  logic [MDAY_W-1:0] cur_mday,
    input  logic              min_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              alarm_flag,
    output logic              irq_pull_low
);

    alarm_field_t fld_min, fld_hour, fld_day;
    logic         mode_day, irq_en_q, irq_en_nxt, flag_clr;
    logic         all_hit, evt;

    alarm_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fld_min    (fld_min),
        .fld_hour   (fld_hour),
        .fld_day    (fld_day),
        .mode_day   (mode_day),
        .irq_en_q   (irq_en_q),
        .irq_en_nxt (irq_en_nxt),
        .flag_clr   (flag_clr)
    );

    alarm_compare #(
        .MIN_W  (MIN_W),
        .HOUR_W (HOUR_W),
        .MDAY_W (MDAY_W),
        .WDAY_N (WDAY_N)
    ) u_cmp (
        .fld_min  (fld_min),
        .fld_hour (fld_hour),
        .fld_day  (fld_day),
        .mode_day (mode_day),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .cur_wday (cur_wday),
        .cur_mday (cur_mday),
        .all_hit  (all_hit)
    );

    // Evaluate the match only on the minute carry.
    assign evt = min_tick && all_hit;

    alarm_flag_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .flag_clr     (flag_clr),
        .irq_en_nxt   (irq_en_nxt),
        .alarm_flag   (alarm_flag),
        .irq_pull_low (irq_pull_low)
    );

endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       min_tick,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       evt,
    input logic       irq_en_q,
    input logic       alarm_flag,
    input logic       irq_pull_low
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == 2'd3) && !wr_data[2];

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) evt |=> alarm_flag); // R3
    AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!alarm_flag && !min_tick) |=> !alarm_flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (alarm_flag && !clr_wr) |=> alarm_flag); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (evt && clr_wr) |=> alarm_flag); // R9
    AST_PIN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_pull_low |-> (alarm_flag && irq_en_q)); // R10
    AST_PIN_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (alarm_flag && irq_en_q) |-> irq_pull_low); // R10

endmodule

bind alarm_match_irq alarm_irq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .min_tick     (min_tick),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .evt          (evt),
    .irq_en_q     (irq_en_q),
    .alarm_flag   (alarm_flag),
    .irq_pull_low (irq_pull_low)
);

// File: tb/alarm_match_irq_bench.sv
`timescale 1ns/1ps
module alarm_match_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [6:0] cur_wday = 7'h01;
    logic [5:0] cur_mday = 6'h01;
    logic       min_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alarm_flag, irq_pull_low;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the register state
    logic [7:0] m_min = '0, m_hour = '0, m_day = '0;
    logic       m_mode = 1'b0, m_en = 1'b0, m_flag = 1'b0;

    always #4 clk = ~clk;

    alarm_match_irq u_alarm_match_irq (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday), .min_tick(min_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flag(alarm_flag), .irq_pull_low(irq_pull_low)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit model_hit();
        bit m_ok, h_ok, d_ok;
        m_ok = m_min[7]  || (m_min[6:0]  == cur_min);
        h_ok = m_hour[7] || (m_hour[6:0] == {1'b0, cur_hour});
        if (m_day[7])    d_ok = 1'b1;
        else if (m_mode) d_ok = (m_day[6:0] == {1'b0, cur_mday});
        else             d_ok = ((m_day[6:0] & cur_wday) != 7'h00);
        return m_ok && h_ok && d_ok;
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (alarm_flag !== m_flag || irq_pull_low !== (m_flag & m_en)) begin
            n_bad++;
            $display("FAIL %s flag=%b pin=%b expected flag=%b pin=%b",
                     tag, alarm_flag, irq_pull_low, m_flag, m_flag & m_en);
        end
    endtask

    // One clock: drive inputs, advance model at the edge, check after it.
    task automatic step(input bit tk, input bit we, input logic [1:0] a,
                        input logic [7:0] d, input string tag);
        bit ev, clr;
        min_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        ev  = tk && model_hit();
        clr = we && (a == 2'd3) && !d[2];
        m_flag = ev || (m_flag && !clr);
        if (we) begin
            case (a)
                2'd0: m_min  = d;
                2'd1: m_hour = d;
                2'd2: m_day  = d;
                default: begin m_mode = d[0]; m_en = d[1]; end
            endcase
        end
        #1;
        min_tick = 1'b0; wr_en = 1'b0;
        check(tag);
    endtask

    task automatic set_time(input int mi, input int hr, input int wd, input int md);
        cur_min  = to_bcd(mi)[6:0];
        cur_hour = to_bcd(hr)[5:0];
        cur_wday = 7'(1 << wd);
        cur_mday = to_bcd(md)[5:0];
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset state");
        // R1: reset fields give weekday mask 0, so a tick cannot hit
        step(1, 0, 0, 0, "R1 no hit from reset fields");

        // R3: exact minute/hour, weekday mask
        set_time(30, 12, 2, 15);
        step(0, 1, 2'd0, 8'h30, "R2 write minute");
        step(0, 1, 2'd1, 8'h12, "R2 write hour");
        step(0, 1, 2'd2, 8'h04, "R2 write day");
        step(0, 0, 0, 0, "R7 match without tick");
        step(1, 0, 0, 0, "R3 exact hit sets flag");
        step(0, 1, 2'd3, 8'h04, "R8 write 1 keeps flag");
        step(0, 1, 2'd3, 8'h06, "R10 enable drives pin");
        step(0, 1, 2'd3, 8'h04, "R10 disable releases pin");
        step(0, 1, 2'd3, 8'h02, "R8 clear flag");
        // R4: multi-day mask, only Wed hit
        step(0, 1, 2'd2, 8'h2A, "R4 mask write");
        set_time(30, 12, 2, 15);
        step(1, 0, 0, 0, "R4 mask miss day2");
        set_time(30, 12, 3, 15);
        step(1, 0, 0, 0, "R4 mask hit day3");
        step(0, 1, 2'd3, 8'h02, "R8 clear");
        // R5: day mode
        step(0, 1, 2'd2, 8'h15, "R5 day write");
        step(0, 1, 2'd3, 8'h07, "R5 day mode on");
        set_time(30, 12, 3, 16);
        step(1, 0, 0, 0, "R5 day miss");
        set_time(30, 12, 3, 15);
        step(1, 0, 0, 0, "R5 day hit");
        // R9: hit and clear together
        step(1, 1, 2'd3, 8'h03, "R9 set beats clear");
        step(0, 1, 2'd3, 8'h03, "R8 clear");
        // R6: ignore minute
        step(0, 1, 2'd0, 8'h80, "R6 minute ignore");
        set_time(47, 12, 3, 15);
        step(1, 0, 0, 0, "R6 ignored minute hits");
        step(0, 1, 2'd3, 8'h03, "R8 clear");
        // R11: write makes hour mismatch in tick cycle; old values used
        step(1, 1, 2'd1, 8'h13, "R11 old hour used");
        step(0, 1, 2'd3, 8'h03, "R8 clear");
        step(1, 0, 0, 0, "R11 new hour applied");

        // Random mix
        for (int it = 0; it < 1500; it++) begin
            int mi, hr, wd, md;
            logic [7:0] d;
            mi = int'($urandom % 60); hr = int'($urandom % 24);
            wd = int'($urandom % 7);  md = 1 + int'($urandom % 31);
            set_time(mi, hr, wd, md);
            if ($urandom % 3 != 0) begin
                d = ($urandom % 2) ? {1'b0, cur_min} : 8'($urandom % 128);
                if ($urandom % 4 == 0) d[7] = 1'b1;
                step(0, 1, 2'd0, d, "R2 rand minute");
                d = ($urandom % 2) ? {2'b0, cur_hour} : 8'($urandom % 64);
                if ($urandom % 4 == 0) d[7] = 1'b1;
                step(0, 1, 2'd1, d, "R2 rand hour");
                if ($urandom % 2 == 0) d = {2'b0, cur_mday};
                else d = ($urandom % 2) ? {1'b0, cur_wday | 7'($urandom)} : 8'($urandom % 128);
                if ($urandom % 4 == 0) d[7] = 1'b1;
                step(0, 1, 2'd2, d, "R4 rand day field");
            end
            d = 8'($urandom % 8);
            step(0, 1, 2'd3, d, "R10 rand control");
            step(($urandom % 4) != 0, ($urandom % 5) == 0, 2'd3, 8'($urandom % 8), "R3 rand tick");
            step(0, 0, 0, 0, "R7 idle");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule